// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This controller sits on the host side of a multiplexed 8-bit converter that is driven by a chip-select and read strobe pair. The converter has a channel address input, a ready line that an external pull-up holds high and that the converter pulls low while it converts, and a parallel data bus. The controller cycles through the channels that a mask enables. It visits them in ascending order and wraps round. It places each result in a per-channel register bank and announces it with a one-cycle pulse that carries the channel number.

A scan runs in one of two protocols, chosen when the scan starts. In the wait protocol the strobe is held low until the converter releases ready. The data on the bus then belongs to the channel just addressed. In the lagged protocol every strobe is a fixed short pulse. That pulse starts a new conversion and also collects the result of the one before it. The controller therefore tags each sample with the channel of the previous strobe. The first sample after a start is stale and is thrown away.

Strobe starts are kept at least a fixed minimum number of cycles apart. They can be spread further with a run-time interval. The channel address changes only while the strobe is high and only after a hold time. In the wait protocol, a ready line that never releases is cut off by a run-time limit, and a sticky error flag is raised. All timings are counted in system clock cycles.

Top module: `adc_scan_ctrl`

## Requirements
- R1: Bit i of `ch_mask` enables channel i. Results are produced for enabled channels only, in ascending channel order. After the highest enabled channel the scan wraps to the lowest, and every scan starts from the lowest enabled channel.
- R2: `adc_addr` is driven at least one cycle before the strobe falls. It stays constant while the strobe is low and for at least HOLD_CYC cycles after the strobe rises.
- R3: `adc_cs_n` and `adc_rd_n` always carry the same value. Both are 1 (high) when idle and 0 during a strobe.
- R4: With `wait_mode`=1 at scan start, the strobe stays low until `adc_rdy`=1, ignoring ready for the first RDY_BLANK cycles. Then `adc_data` is stored and reported with the channel that was addressed.
- R5: With `wait_mode`=0 at scan start, each strobe is exactly RD_PULSE cycles low. The sampled data is reported with the channel of the previous strobe, and the first strobe after a start produces no result.
- R6: Consecutive strobe falls are max(`interval`, MIN_SPACE) cycles apart whenever the strobe ends earlier than that. They are never closer than MIN_SPACE.
- R7: While `ch_mask` is zero, the controller stays idle: no strobe and no result.
- R8: In the wait protocol, a strobe with ready still low after `timeout_lim` cycles is released. That strobe gives no result and sets `timeout_err`, and the scan goes on with the next channel. `timeout_err` stays set until the next scan start.
- R9: `rd_data` shows the last result stored for channel `rd_ch`. Every entry reads 0 after reset.
- R10: `res_valid` is high for exactly one cycle per result, with `res_ch` and `res_data` valid in that cycle.
- R11: After reset, `adc_cs_n`=1, `adc_rd_n`=1, `res_valid`=0 and `timeout_err`=0.
- R12: When `enable` falls, the strobe in progress completes and the controller goes idle. A later start drops the lag, so its first reported sample comes from a conversion of that new scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Run the scan while high |
| wait_mode | input | 1 | 1 = hold strobe until ready, 0 = fixed pulse with one-sample lag; taken at scan start |
| ch_mask | input | NUM_CH | Channel enable mask, bit i = channel i |
| interval | input | CNT_W | Requested cycles between strobe starts (raised to MIN_SPACE) |
| timeout_lim | input | CNT_W | Cycles a wait-protocol strobe may last |
| adc_rdy | input | 1 | Converter ready, 1 = released |
| adc_data | input | DATA_W | Converter data bus |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_rd_n | output | 1 | Converter read strobe, active low |
| adc_addr | output | ADDR_W | Converter channel address |
| res_valid | output | 1 | One-cycle result pulse |
| res_ch | output | ADDR_W | Channel of the reported result |
| res_data | output | DATA_W | Reported sample |
| rd_ch | input | ADDR_W | Register bank read index |
| rd_data | output | DATA_W | Register bank read data |
| timeout_err | output | 1 | Sticky ready timeout flag |

## Verification
The assertions check the pin-level timing on every cycle. The address stays frozen during a strobe and for the hold window after it, and it moves only while the strobe is high. Chip select and read track each other. Strobe starts never come closer than the minimum spacing. The result pulse never lasts two cycles. The bench scenarios are needed for everything else. Only a converter model can show the channel order and wrap across a mask, and the one-sample tag lag with the discarded first read in the lagged protocol. The same goes for the exact pulse width and interval spacing, the timeout and how the scan recovers from it, the idle state with an empty mask, and the bank contents.

// File: rtl/adc_scan_pkg.sv
// Shared definitions for the ADC scan sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package adc_scan_pkg;

    // Transaction phases of one converter access.
    typedef enum logic [2:0] {
        ST_IDLE,    // no scan running
        ST_SETUP,   // address driven, strobe still high
        ST_STROBE,  // strobe low
        ST_HOLD,    // strobe high, address held
        ST_GAP      // waiting for the spacing window
    } scan_state_e;

endpackage

// File: rtl/adc_chan_pick.sv
// Finds the next enabled channel above a given index, wrapping to 0.
// With from_top set, it returns the lowest enabled channel.
// Assumes: NUM_CH >= 1; pure combinational logic.
module adc_chan_pick #(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 3
) (
    input  logic [NUM_CH-1:0] mask,
    input  logic [ADDR_W-1:0] after,
    input  logic              from_top,
    output logic              found,
    output logic [ADDR_W-1:0] next_ch
);

    // Ascending search with wrap; the nearest candidate is assigned last and wins.
    always_comb begin
        int unsigned base;
        found   = 1'b0;
        next_ch = '0;
        base    = from_top ? 32'(NUM_CH - 1) : 32'(after);
        for (int k = NUM_CH; k >= 1; k--) begin
            int unsigned idx;
            idx = (base + 32'(k)) % 32'(NUM_CH);
            if (mask[idx]) begin
                found   = 1'b1;
                next_ch = ADDR_W'(idx);
            end
        end
    end

endmodule

// File: rtl/adc_result_bank.sv
// Per-channel result registers: one write port, one combinational read port.
// Assumes: writes come from registered result signals; out-of-range reads give 0.
module adc_result_bank #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_ch,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_ch,
    output logic [DATA_W-1:0] rd_data
);

    logic [NUM_CH-1:0][DATA_W-1:0] slots;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        logic [DATA_W-1:0] r;
        // Capture a result addressed to this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)
                r <= '0;
            else if (wr_en && wr_ch == ADDR_W'(g))
                r <= wr_data;
        end
        assign slots[g] = r;
    end

    // Read the selected slot.
    always_comb begin
        rd_data = '0;
        if (32'(rd_ch) < 32'(NUM_CH))
            rd_data = slots[rd_ch];
    end

endmodule

// File: rtl/adc_xfer_fsm.sv
// Strobe timing and result capture for the scan sequencer.
// Runs setup, strobe, hold and gap per channel. Applies the wait or lagged
// protocol, the spacing rule and the ready timeout.
// Assumes: MIN_SPACE > RD_PULSE + HOLD_CYC + 2; HOLD_CYC >= 1; timeout_lim >= 1.
module adc_xfer_fsm
    import adc_scan_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 3,
    parameter int CNT_W     = 16,
    parameter int MIN_SPACE = 500,
    parameter int RD_PULSE  = 16,
    parameter int HOLD_CYC  = 8,
    parameter int RDY_BLANK = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wait_mode,
    input  logic [CNT_W-1:0]  interval,
    input  logic [CNT_W-1:0]  timeout_lim,
    input  logic              adc_rdy,
    input  logic [DATA_W-1:0] adc_data,
    input  logic              pick_found,
    input  logic [ADDR_W-1:0] pick_ch,
    output logic              pick_from_top,
    output logic [ADDR_W-1:0] cur_ch,
    output logic              strobe,
    output logic              res_valid,
    output logic [ADDR_W-1:0] res_ch,
    output logic [DATA_W-1:0] res_data,
    output logic              timeout_err
);

    localparam int HOLD_W = $clog2(HOLD_CYC + 1);

    scan_state_e       state;
    logic [CNT_W-1:0]  since_start;   // cycles since the strobe went low
    logic [HOLD_W-1:0] hold_cnt;
    logic              mode_wait;
    logic              lag_vld;
    logic [ADDR_W-1:0] lag_ch;
    logic [CNT_W-1:0]  space_lim;
    logic              gap_ok;

    // Effective spacing: the larger of the request and the floor.
    always_comb begin
        space_lim = (interval > CNT_W'(MIN_SPACE)) ? interval : CNT_W'(MIN_SPACE);
        gap_ok    = since_start >= space_lim - CNT_W'(2);
    end

    assign pick_from_top = (state == ST_IDLE);
    assign strobe        = (state == ST_STROBE);

    // Sequence the transaction and capture results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            since_start <= '0;
            hold_cnt    <= '0;
            cur_ch      <= '0;
            mode_wait   <= 1'b1;
            lag_vld     <= 1'b0;
            lag_ch      <= '0;
            res_valid   <= 1'b0;
            res_ch      <= '0;
            res_data    <= '0;
            timeout_err <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            if (since_start != '1)
                since_start <= since_start + 1'b1;
            case (state)
                ST_IDLE: begin
                    lag_vld <= 1'b0;
                    if (enable && pick_found) begin
                        cur_ch      <= pick_ch;
                        mode_wait   <= wait_mode;
                        timeout_err <= 1'b0;
                        state       <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    since_start <= '0;
                    state       <= ST_STROBE;
                end
                ST_STROBE: begin
                    if (mode_wait) begin
                        if (since_start >= CNT_W'(RDY_BLANK) && adc_rdy) begin
                            res_valid <= 1'b1;
                            res_ch    <= cur_ch;
                            res_data  <= adc_data;
                            hold_cnt  <= '0;
                            state     <= ST_HOLD;
                        end else if (since_start >= timeout_lim - CNT_W'(1)) begin
                            timeout_err <= 1'b1;
                            hold_cnt    <= '0;
                            state       <= ST_HOLD;
                        end
                    end else if (since_start == CNT_W'(RD_PULSE - 1)) begin
                        if (lag_vld) begin
                            res_valid <= 1'b1;
                            res_ch    <= lag_ch;
                            res_data  <= adc_data;
                        end
                        lag_vld  <= 1'b1;
                        lag_ch   <= cur_ch;
                        hold_cnt <= '0;
                        state    <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    hold_cnt <= hold_cnt + 1'b1;
                    if (hold_cnt == HOLD_W'(HOLD_CYC - 1))
                        state <= ST_GAP;
                end
                ST_GAP: begin
                    if (gap_ok) begin
                        if (enable && pick_found) begin
                            cur_ch <= pick_ch;
                            state  <= ST_SETUP;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adc_scan_ctrl.sv
// Top of the multi-channel ADC scan sequencer.
// Joins the channel picker, the transfer state machine and the result bank,
// and drives the converter pins.
// Assumes: the converter's ready line has an external pull-up (1 = released).
module adc_scan_ctrl #(
    parameter int NUM_CH    = 8,
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 16,
    parameter int MIN_SPACE = 500,
    parameter int RD_PULSE  = 16,
    parameter int HOLD_CYC  = 8,
    parameter int RDY_BLANK = 2,
    localparam int ADDR_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wait_mode,
    input  logic [NUM_CH-1:0] ch_mask,
    input  logic [CNT_W-1:0]  interval,
    input  logic [CNT_W-1:0]  timeout_lim,
    input  logic              adc_rdy,
    input  logic [DATA_W-1:0] adc_data,
    output logic              adc_cs_n,
    output logic              adc_rd_n,
    output logic [ADDR_W-1:0] adc_addr,
    output logic              res_valid,
    output logic [ADDR_W-1:0] res_ch,
    output logic [DATA_W-1:0] res_data,
    input  logic [ADDR_W-1:0] rd_ch,
    output logic [DATA_W-1:0] rd_data,
    output logic              timeout_err
);

    logic              pick_found;
    logic [ADDR_W-1:0] pick_ch;
    logic              pick_from_top;
    logic [ADDR_W-1:0] cur_ch;
    logic              strobe;

    adc_chan_pick #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) pick_i (
        .mask     (ch_mask),
        .after    (cur_ch),
        .from_top (pick_from_top),
        .found    (pick_found),
        .next_ch  (pick_ch)
    );

    adc_xfer_fsm #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MIN_SPACE(MIN_SPACE),
        .RD_PULSE(RD_PULSE), .HOLD_CYC(HOLD_CYC), .RDY_BLANK(RDY_BLANK)
    ) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .wait_mode     (wait_mode),
        .interval      (interval),
        .timeout_lim   (timeout_lim),
        .adc_rdy       (adc_rdy),
        .adc_data      (adc_data),
        .pick_found    (pick_found),
        .pick_ch       (pick_ch),
        .pick_from_top (pick_from_top),
        .cur_ch        (cur_ch),
        .strobe        (strobe),
        .res_valid     (res_valid),
        .res_ch        (res_ch),
        .res_data      (res_data),
        .timeout_err   (timeout_err)
    );

    adc_result_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (res_valid),
        .wr_ch   (res_ch),
        .wr_data (res_data),
        .rd_ch   (rd_ch),
        .rd_data (rd_data)
    );

    assign adc_cs_n = ~strobe;
    assign adc_rd_n = ~strobe;
    assign adc_addr = cur_ch;

endmodule

// File: rtl/adc_scan_ctrl_chk.sv
// Pin-level protocol checker for adc_scan_ctrl, attached by bind.
// Assumes: synchronous active-low reset; counters saturate.
module adc_scan_ctrl_chk #(
    parameter int ADDR_W    = 3,
    parameter int CNT_W     = 16,
    parameter int MIN_SPACE = 500,
    parameter int HOLD_CYC  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adc_cs_n,
    input logic              adc_rd_n,
    input logic [ADDR_W-1:0] adc_addr,
    input logic              res_valid
);

    logic             cs_d;
    logic [CNT_W-1:0] since_fall;
    logic [CNT_W-1:0] since_rise;
    logic             fall_seen;
    logic             rise_seen;

    // Track cycles since the last strobe edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d       <= 1'b1;
            since_fall <= '0;
            since_rise <= '0;
            fall_seen  <= 1'b0;
            rise_seen  <= 1'b0;
        end else begin
            cs_d <= adc_cs_n;
            if (cs_d && !adc_cs_n) begin
                since_fall <= CNT_W'(1);
                fall_seen  <= 1'b1;
            end else if (since_fall != '1) begin
                since_fall <= since_fall + 1'b1;
            end
            if (!cs_d && adc_cs_n) begin
                since_rise <= CNT_W'(1);
                rise_seen  <= 1'b1;
            end else if (since_rise != '1) begin
                since_rise <= since_rise + 1'b1;
            end
        end
    end

    assert_addr_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_cs_n |-> $stable(adc_addr));

    assert_addr_moves_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_addr != $past(adc_addr)) |-> (adc_cs_n && $past(adc_cs_n)));

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_seen && adc_addr != $past(adc_addr)) |-> (since_rise >= CNT_W'(HOLD_CYC)));

    assert_cs_rd_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_rd_n == adc_cs_n);

    assert_min_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(adc_cs_n) && fall_seen) |-> (since_fall >= CNT_W'(MIN_SPACE)));

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MIN_SPACE(MIN_SPACE), .HOLD_CYC(HOLD_CYC)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .adc_cs_n  (adc_cs_n),
    .adc_rd_n  (adc_rd_n),
    .adc_addr  (adc_addr),
    .res_valid (res_valid)
);

// File: tb/adc_scan_ctrl_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench for adc_scan_ctrl with a behavioural converter model.
module adc_scan_ctrl_tb_top;

    localparam int NCH   = 8;
    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int CW    = 16;
    localparam int MINSP = 500;
    localparam int PULSE = 16;
    localparam int HOLD  = 8;
    localparam int CONV  = 400;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           enable = 1'b0;
    logic           wait_mode = 1'b1;
    logic [NCH-1:0] ch_mask = '0;
    logic [CW-1:0]  interval = '0;
    logic [CW-1:0]  timeout_lim = CW'(1000);
    logic           adc_rdy;
    logic [DW-1:0]  adc_data;
    logic           adc_cs_n, adc_rd_n;
    logic [AW-1:0]  adc_addr;
    logic           res_valid;
    logic [AW-1:0]  res_ch;
    logic [DW-1:0]  res_data;
    logic [AW-1:0]  rd_ch = '0;
    logic [DW-1:0]  rd_data;
    logic           timeout_err;

    always #2.5 clk = ~clk;

    adc_scan_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wait_mode(wait_mode),
        .ch_mask(ch_mask), .interval(interval), .timeout_lim(timeout_lim),
        .adc_rdy(adc_rdy), .adc_data(adc_data), .adc_cs_n(adc_cs_n),
        .adc_rd_n(adc_rd_n), .adc_addr(adc_addr), .res_valid(res_valid),
        .res_ch(res_ch), .res_data(res_data), .rd_ch(rd_ch), .rd_data(rd_data),
        .timeout_err(timeout_err)
    );

    int     nchk = 0;
    int     nfail = 0;
    longint cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Converter model: conversion starts on the strobe fall, ends CONV cycles later.
    logic [DW-1:0] done_code [NCH];
    logic [4:0]    seq;
    logic          busy, m_prev_cs, stuck = 1'b0;
    int            mcnt;
    logic [AW-1:0] mch;

    always @(posedge clk) begin
        if (!rst_n) begin
            adc_rdy <= 1'b1; adc_data <= '0; seq <= '0; busy <= 1'b0;
            m_prev_cs <= 1'b1; mcnt <= 0; mch <= '0;
            for (int i = 0; i < NCH; i++) done_code[i] <= '0;
        end else begin
            m_prev_cs <= adc_cs_n;
            if (m_prev_cs && !adc_cs_n) begin
                mch <= adc_addr; busy <= 1'b1; mcnt <= 0; adc_rdy <= 1'b0;
            end else begin
                if (busy) begin
                    if (mcnt == CONV - 1) begin
                        busy <= 1'b0;
                        done_code[mch] <= {mch, seq};
                        adc_data <= {mch, seq};
                        seq <= seq + 1'b1;
                        if (!adc_cs_n && !stuck) adc_rdy <= 1'b1;
                    end else begin
                        mcnt <= mcnt + 1;
                    end
                end
                if (adc_cs_n) adc_rdy <= 1'b1;
            end
        end
    end

    // Scoreboard and pin monitor.
    int            exp_q[$];
    int            exp_gap = 0, exp_width = 0;
    int            nvalid = 0, nfalls = 0;
    longint        last_fall = -1, last_rise = -1;
    logic          prev_cs = 1'b1, prev_valid = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    logic [DW-1:0] seen_bank [NCH];

    initial for (int i = 0; i < NCH; i++) seen_bank[i] = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_cs && !adc_cs_n) begin
                nfalls++;
                check(adc_rd_n == adc_cs_n, "R3 read follows select", adc_rd_n, adc_cs_n);
                if (last_fall >= 0 && exp_gap > 0)
                    check(cyc - last_fall == exp_gap, "R6 strobe spacing", cyc - last_fall, exp_gap);
                last_fall = cyc;
            end
            if (!prev_cs && adc_cs_n) begin
                last_rise = cyc;
                if (exp_width > 0)
                    check(cyc - last_fall == exp_width, "R5/R8 strobe width", cyc - last_fall, exp_width);
            end
            if (adc_addr != prev_addr)
                check(adc_cs_n && prev_cs &&
                      (last_fall < 0 || (last_rise > last_fall && cyc - last_rise >= HOLD)),
                      "R2 address change timing", cyc - last_rise, HOLD);
            if (res_valid) begin
                check(!prev_valid, "R10 single-cycle valid", 1, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected result", res_ch, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(int'(res_ch) == e, "R1 channel order", res_ch, e);
                    check(res_data == done_code[res_ch], "R4/R5 sample data", res_data, done_code[res_ch]);
                end
                seen_bank[res_ch] = res_data;
                nvalid++;
            end
            prev_cs    = adc_cs_n;
            prev_valid = res_valid;
            prev_addr  = adc_addr;
        end
    end

    // Driver: push the expected channel order for a mask.
    task automatic push_seq(input logic [NCH-1:0] mask, input int n);
        int c = -1;
        for (int k = 0; k < n; k++) begin
            for (int s = 1; s <= NCH; s++) begin
                int idx;
                idx = (c + s + NCH) % NCH;
                if (mask[idx]) begin
                    c = idx;
                    break;
                end
            end
            exp_q.push_back(c);
        end
    endtask

    task automatic run_scan(input bit wmode, input logic [NCH-1:0] mask, input int ival,
                            input int nres, input string tag);
        int v0, f1, first;
        exp_q.delete();
        push_seq(mask, nres + 4);
        first     = exp_q[0];
        exp_gap   = (ival > MINSP) ? ival : MINSP;
        exp_width = wmode ? 0 : PULSE;
        last_fall = -1;
        wait_mode = wmode;
        ch_mask   = mask;
        interval  = CW'(ival);
        v0        = nvalid;
        enable    = 1'b1;
        while (nvalid == v0) @(negedge clk);
        check(int'(res_ch) == first, {tag, " first result after start"}, res_ch, first);
        while (nvalid - v0 < nres) @(negedge clk);
        enable = 1'b0;
        repeat (exp_gap + CONV + 200) @(negedge clk);
        check(adc_cs_n == 1'b1, "R12 idle after enable drop", adc_cs_n, 1);
        f1 = nfalls;
        repeat (1000) @(negedge clk);
        check(nfalls == f1, "R12 no strobe while disabled", nfalls, f1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int v0, f0, n;
        repeat (5) @(negedge clk);
        check(adc_cs_n == 1'b1 && adc_rd_n == 1'b1, "R11 strobe idle in reset", adc_cs_n, 1);
        check(res_valid == 1'b0, "R11 no result in reset", res_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(timeout_err == 1'b0, "R11 error clear after reset", timeout_err, 0);
        for (int c = 0; c < NCH; c++) begin
            rd_ch = AW'(c);
            #1;
            check(rd_data == '0, "R9 bank zero after reset", rd_data, 0);
            @(negedge clk);
        end

        // Wait protocol, sparse mask with wrap, interval below the floor.
        run_scan(1'b1, 8'b1010_0110, 10, 10, "R1");
        check(timeout_err == 1'b0, "R8 no error on normal scan", timeout_err, 0);
        for (int c = 0; c < NCH; c++) begin
            rd_ch = AW'(c);
            #1;
            check(rd_data == seen_bank[c], "R9 bank readback", rd_data, seen_bank[c]);
            @(negedge clk);
        end

        // Lagged protocol with a longer interval.
        run_scan(1'b0, 8'b0000_1001, 700, 5, "R5");
        // Restart with a new mask: the lag must not carry over.
        run_scan(1'b0, 8'b0110_0000, 0, 4, "R12");

        // Empty mask keeps the controller idle.
        exp_gap = 0; exp_width = 0;
        f0 = nfalls; v0 = nvalid;
        ch_mask = '0; enable = 1'b1;
        repeat (2000) @(negedge clk);
        check(nfalls == f0, "R7 no strobe with empty mask", nfalls, f0);
        check(nvalid == v0, "R7 no result with empty mask", nvalid, v0);
        enable = 1'b0;
        @(negedge clk);

        // Ready timeout, then recovery.
        exp_q.delete();
        push_seq(8'b0001_0000, 4);
        stuck = 1'b1; timeout_lim = CW'(50);
        exp_gap = MINSP; exp_width = 50; last_fall = -1;
        wait_mode = 1'b1; interval = '0; ch_mask = 8'b0001_0000;
        v0 = nvalid; enable = 1'b1;
        n = 0;
        while (!timeout_err && n < 3000) begin @(negedge clk); n++; end
        check(timeout_err == 1'b1, "R8 timeout flag set", timeout_err, 1);
        repeat (100) @(negedge clk);
        check(nvalid == v0, "R8 no result on timeout", nvalid, v0);
        exp_width = 0; stuck = 1'b0; timeout_lim = CW'(1000);
        n = 0;
        while (nvalid == v0 && n < 3000) begin @(negedge clk); n++; end
        check(nvalid == v0 + 1 && res_ch == AW'(4), "R8 scan continues after timeout", res_ch, 4);
        check(timeout_err == 1'b1, "R8 error flag sticky", timeout_err, 1);
        enable = 1'b0;
        repeat (MINSP + CONV + 200) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule